// File: doc/BRIEF.md
# Region Start-Address System Register with Access Permission Checking

This block holds one 64-bit control register that describes where an ordered memory region starts and whether that region is enabled. Software reaches it only through a system-instruction decode port. Each request on that port carries a five-field instruction encoding, a read/write flag, write data, the current privilege level (0 to 3) and the security and trap-control state of the core.

For a request whose encoding selects this register, the block runs a priority-ordered permission check for the requesting privilege level. The access then ends in one of four ways: it completes, it is reported as an undefined instruction, or it is reported as a trap to level 2 or to level 3 with a fixed syndrome class. A completed write stores the value with every reserved bit forced to zero. A completed read returns the stored value.

The implemented physical-address width and the register-present option are static parameters. The combined "52-bit addressing with a 64KB granule" mode is an input. The block does not do translation lookups, descriptor selection or exception entry.

Top module: `sysreg_region_base`

## Requirements
- R1: Only the encoding op0=2'b11, op1=3'b000, CRn=4'b1010, CRm=4'b0100, op2=3'b000 is claimed. A request with any other encoding produces no `acc_done` pulse and does not change the stored value.
- R2: A claimed request with `req_valid` high in cycle N gives `acc_done` high for exactly cycle N+1. In that cycle `acc_result`, `acc_target`, `acc_class` and `acc_rdata` are valid. `acc_result` encodes 2'b00 = complete, 2'b01 = undefined, 2'b10 = trap to level 2, 2'b11 = trap to level 3.
- R3: Every access from level 0 is undefined. At levels 1, 2 and 3, the access is undefined whenever `nonsecure` is 0.
- R4: At level 1 with `nonsecure`=1, the access traps to level 2 if `l2_enabled`, `l2_is_64bit` and `l2_trap` are all 1. Otherwise it traps to level 3 if `l3_present`, `l3_is_64bit` and `l3_trap` are all 1. Otherwise it completes.
- R5: At level 2 with `nonsecure`=1, only the level-3 trap condition of R4 applies and the level-2 inputs have no effect. At level 3 with `nonsecure`=1, the access always completes.
- R6: A trap reports `acc_class` = 6'h18 and `acc_target` = 2 or 3. Complete and undefined results report `acc_class` = 0 and `acc_target` = 0.
- R7: Bit 0 is the region enable flag (1 = enabled) and reads 0 after reset. The other stored bits have no defined reset value.
- R8: Bits 15:1 and 63:52 always read as 0. Bits 47:16 hold start-address bits 47:16 and read back as written (address bits 15:0 are implicitly zero).
- R9: Bits 51:48 keep written data only when `wide_pa_64k` is 1 at the write, and read as 0 whenever `wide_pa_64k` is 0.
- R10: Any bit at position PA_BITS or higher reads as 0.
- R11: A write whose result is undefined or a trap leaves the stored value unchanged.
- R12: With REG_PRESENT=0 the register reads as 0 and ignores writes, while the R3 to R6 permission results are unchanged.
- R13: Read data is 0 in every cycle where `acc_done` is low, and for writes and for reads that do not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Privilege level of the requester |
| nonsecure | input | 1 | Non-secure state flag |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_is_64bit | input | 1 | Level 2 runs in 64-bit state |
| l2_trap | input | 1 | Level-2 trap control for this register |
| l3_present | input | 1 | Level 3 is implemented |
| l3_is_64bit | input | 1 | Level 3 runs in 64-bit state |
| l3_trap | input | 1 | Level-3 trap control for this register |
| wide_pa_64k | input | 1 | 52-bit addressing with a 64KB granule is active |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_result | output | 2 | Result code |
| acc_target | output | 2 | Trap target level, 0 when there is no trap |
| acc_class | output | 6 | Syndrome class, 6'h18 on a trap |
| acc_rdata | output | 64 | Read data |

## Verification
The assertions assume that the trap-control and mode inputs are steady in the cycle after a request. The one that relates a refused write to the held value needs `wide_pa_64k` to stay the same across that cycle. They also assume that requests never overlap a pulse in a way that hides one. The bench drives every input on the falling edge and holds the control inputs through both the request cycle and the response cycle. It leaves one idle cycle between requests, so each `acc_done` pulse belongs to exactly one request. It changes `wide_pa_64k` only between accesses.

// File: rtl/sysreg_region_pkg.sv
package sysreg_region_pkg;

  typedef enum logic [1:0] {
    RES_OK    = 2'b00,
    RES_UNDEF = 2'b01,
    RES_TRAP2 = 2'b10,
    RES_TRAP3 = 2'b11
  } acc_result_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysenc_t;

  localparam sysenc_t REGION_BASE_ENC = '{op0: 2'b11, op1: 3'b000, crn: 4'b1010,
                                           crm: 4'b0100, op2: 3'b000};
  localparam logic [5:0] TRAP_CLASS = 6'h18;
  localparam int REG_W   = 64;
  localparam int ADDR_LO = 16;
  localparam int ADDR_HI = 51;
  localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
  localparam int WIDE_LO = 48;

endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match
  import sysreg_region_pkg::*;
#(
  parameter sysenc_t MATCH_ENC = REGION_BASE_ENC
) (
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  sysenc_t enc;

  always_comb begin
    enc = '{op0: op0, op1: op1, crn: crn, crm: crm, op2: op2};
    hit = (enc == MATCH_ENC);
  end
endmodule

// File: rtl/sysreg_perm_check.sv
module sysreg_perm_check
  import sysreg_region_pkg::*;
(
  input  logic [1:0]  level,
  input  logic        nonsecure,
  input  logic        l2_enabled,
  input  logic        l2_is_64bit,
  input  logic        l2_trap,
  input  logic        l3_present,
  input  logic        l3_is_64bit,
  input  logic        l3_trap,
  output acc_result_e verdict
);
  logic l2_hits;
  logic l3_hits;

  always_comb begin
    l2_hits = l2_enabled & l2_is_64bit & l2_trap;
    l3_hits = l3_present & l3_is_64bit & l3_trap;
    verdict = RES_OK;
    unique case (level)
      2'd0: verdict = RES_UNDEF;
      2'd1: begin
        if (!nonsecure)   verdict = RES_UNDEF;
        else if (l2_hits) verdict = RES_TRAP2;
        else if (l3_hits) verdict = RES_TRAP3;
        else              verdict = RES_OK;
      end
      2'd2: begin
        if (!nonsecure)   verdict = RES_UNDEF;
        else if (l3_hits) verdict = RES_TRAP3;
        else              verdict = RES_OK;
      end
      default: verdict = nonsecure ? RES_OK : RES_UNDEF;
    endcase
  end
endmodule

// File: rtl/sysreg_region_store.sv
module sysreg_region_store
  import sysreg_region_pkg::*;
#(
  parameter int PA_BITS     = 52,
  parameter bit REG_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_enable_bit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wide_mode,
  output logic [REG_W-1:0]  value
);
  localparam int PA_LIM = (PA_BITS > ADDR_HI + 1) ? ADDR_HI + 1 : PA_BITS;
  localparam int WIDE_IDX = WIDE_LO - ADDR_LO;

  function automatic logic [ADDR_W-1:0] width_mask();
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i + ADDR_LO) < PA_LIM;
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] PA_MASK = width_mask();

  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] mode_mask;
  logic              wr_gated;

  always_comb begin
    mode_mask = PA_MASK;
    if (!wide_mode) mode_mask[ADDR_W-1:WIDE_IDX] = '0;
    wr_gated = wr_en & REG_PRESENT;
    en_d     = wr_gated ? wr_enable_bit : en_q;
    addr_d   = wr_gated ? (wr_addr & mode_mask) : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (wr_gated) en_q <= en_d;
  end

  always_ff @(posedge clk) begin
    if (wr_gated) addr_q <= addr_d;
  end

  always_comb begin
    value = '0;
    if (REG_PRESENT) begin
      value[0]              = en_q;
      value[ADDR_HI:ADDR_LO] = addr_q & mode_mask;
    end
  end
endmodule

// File: rtl/sysreg_region_base.sv
module sysreg_region_base
  import sysreg_region_pkg::*;
#(
  parameter int PA_BITS     = 52,
  parameter bit REG_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic        req_write,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  cur_level,
  input  logic        nonsecure,
  input  logic        l2_enabled,
  input  logic        l2_is_64bit,
  input  logic        l2_trap,
  input  logic        l3_present,
  input  logic        l3_is_64bit,
  input  logic        l3_trap,
  input  logic        wide_pa_64k,
  output logic        acc_done,
  output logic [1:0]  acc_result,
  output logic [1:0]  acc_target,
  output logic [5:0]  acc_class,
  output logic [63:0] acc_rdata
);
  logic        enc_hit;
  logic        claim;
  acc_result_e verdict;
  logic        commit_wr;
  logic [63:0] cur_value;

  logic        done_q, done_d;
  logic [1:0]  result_q, result_d;
  logic [1:0]  target_q, target_d;
  logic [5:0]  class_q, class_d;
  logic [63:0] rdata_q, rdata_d;

  sysreg_enc_match u_match (
    .op0 (req_op0), .op1 (req_op1), .crn (req_crn),
    .crm (req_crm), .op2 (req_op2), .hit (enc_hit)
  );

  sysreg_perm_check u_perm (
    .level       (cur_level),
    .nonsecure   (nonsecure),
    .l2_enabled  (l2_enabled),
    .l2_is_64bit (l2_is_64bit),
    .l2_trap     (l2_trap),
    .l3_present  (l3_present),
    .l3_is_64bit (l3_is_64bit),
    .l3_trap     (l3_trap),
    .verdict     (verdict)
  );

  sysreg_region_store #(.PA_BITS(PA_BITS), .REG_PRESENT(REG_PRESENT)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (commit_wr),
    .wr_enable_bit (req_wdata[0]),
    .wr_addr       (req_wdata[ADDR_HI:ADDR_LO]),
    .wide_mode     (wide_pa_64k),
    .value         (cur_value)
  );

  always_comb begin
    claim     = req_valid & enc_hit;
    commit_wr = claim & req_write & (verdict == RES_OK);
    done_d    = claim;
    result_d  = claim ? verdict : RES_OK;
    target_d  = 2'd0;
    class_d   = '0;
    rdata_d   = '0;
    if (claim && (verdict == RES_TRAP2 || verdict == RES_TRAP3)) begin
      target_d = (verdict == RES_TRAP2) ? 2'd2 : 2'd3;
      class_d  = TRAP_CLASS;
    end
    if (claim && !req_write && verdict == RES_OK) rdata_d = cur_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= 2'b00;
      target_q <= 2'd0;
      class_q  <= '0;
      rdata_q  <= '0;
    end else begin
      done_q   <= done_d;
      result_q <= result_d;
      target_q <= target_d;
      class_q  <= class_d;
      rdata_q  <= rdata_d;
    end
  end

  assign acc_done   = done_q;
  assign acc_result = result_q;
  assign acc_target = target_q;
  assign acc_class  = class_q;
  assign acc_rdata  = rdata_q;
endmodule

// File: rtl/sysreg_region_base_chk.sv
module sysreg_region_base_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op0,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic        req_write,
  input logic [1:0]  cur_level,
  input logic        nonsecure,
  input logic        l3_present,
  input logic        l3_is_64bit,
  input logic        l3_trap,
  input logic        wide_pa_64k,
  input logic        acc_done,
  input logic [1:0]  acc_result,
  input logic [1:0]  acc_target,
  input logic [5:0]  acc_class,
  input logic [63:0] acc_rdata,
  input logic [63:0] cur_value
);
  logic sel;
  assign sel = req_valid && req_op0 == 2'b11 && req_op1 == 3'b000 &&
               req_crn == 4'b1010 && req_crm == 4'b0100 && req_op2 == 3'b000;

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> $past(sel));

  assert_claim_answers_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> acc_done);

  assert_level0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cur_level == 2'd0) |=> acc_result == 2'b01);

  assert_level2_only_l3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cur_level == 2'd2 && nonsecure && !(l3_present && l3_is_64bit && l3_trap))
      |=> acc_result == 2'b00);

  assert_trap_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && acc_result[1]) |-> (acc_class == 6'h18 && acc_target == {1'b1, acc_result[0]}));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> (acc_rdata[15:1] == 15'd0 && acc_rdata[63:52] == 12'd0));

  assert_refused_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && acc_result != 2'b00 && $past(req_write) && $stable(wide_pa_64k))
      |-> $stable(cur_value));

  assert_idle_rdata_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_done |-> acc_rdata == 64'd0);
endmodule

bind sysreg_region_base sysreg_region_base_chk u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
  .req_op0 (req_op0), .req_op1 (req_op1), .req_crn (req_crn),
  .req_crm (req_crm), .req_op2 (req_op2), .req_write (req_write),
  .cur_level (cur_level), .nonsecure (nonsecure),
  .l3_present (l3_present), .l3_is_64bit (l3_is_64bit), .l3_trap (l3_trap),
  .wide_pa_64k (wide_pa_64k), .acc_done (acc_done), .acc_result (acc_result),
  .acc_target (acc_target), .acc_class (acc_class), .acc_rdata (acc_rdata),
  .cur_value (cur_value)
);

// File: tb/test_sysreg_region_base.sv
module test_sysreg_region_base;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op0 = 2'b11;
  logic [2:0]  req_op1 = 3'b000;
  logic [3:0]  req_crn = 4'b1010;
  logic [3:0]  req_crm = 4'b0100;
  logic [2:0]  req_op2 = 3'b000;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cur_level = 2'd3;
  logic        nonsecure = 1'b1;
  logic        l2_enabled = 0, l2_is_64bit = 0, l2_trap = 0;
  logic        l3_present = 0, l3_is_64bit = 0, l3_trap = 0;
  logic        wide_pa_64k = 1'b1;

  logic        m_done, n_done, a_done;
  logic [1:0]  m_res, n_res, a_res, m_tgt, n_tgt, a_tgt;
  logic [5:0]  m_cls, n_cls, a_cls;
  logic [63:0] m_rd, n_rd, a_rd;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sysreg_region_base i_sysreg_region_base (
    .clk, .rst_n, .req_valid, .req_op0, .req_op1, .req_crn, .req_crm, .req_op2,
    .req_write, .req_wdata, .cur_level, .nonsecure, .l2_enabled, .l2_is_64bit,
    .l2_trap, .l3_present, .l3_is_64bit, .l3_trap, .wide_pa_64k,
    .acc_done(m_done), .acc_result(m_res), .acc_target(m_tgt), .acc_class(m_cls),
    .acc_rdata(m_rd));

  sysreg_region_base #(.PA_BITS(40)) i_sysreg_region_base_narrow (
    .clk, .rst_n, .req_valid, .req_op0, .req_op1, .req_crn, .req_crm, .req_op2,
    .req_write, .req_wdata, .cur_level, .nonsecure, .l2_enabled, .l2_is_64bit,
    .l2_trap, .l3_present, .l3_is_64bit, .l3_trap, .wide_pa_64k,
    .acc_done(n_done), .acc_result(n_res), .acc_target(n_tgt), .acc_class(n_cls),
    .acc_rdata(n_rd));

  sysreg_region_base #(.REG_PRESENT(1'b0)) i_sysreg_region_base_absent (
    .clk, .rst_n, .req_valid, .req_op0, .req_op1, .req_crn, .req_crm, .req_op2,
    .req_write, .req_wdata, .cur_level, .nonsecure, .l2_enabled, .l2_is_64bit,
    .l2_trap, .l3_present, .l3_is_64bit, .l3_trap, .wide_pa_64k,
    .acc_done(a_done), .acc_result(a_res), .acc_target(a_tgt), .acc_class(a_cls),
    .acc_rdata(a_rd));

  // {level[1:0], ns, l2en, l2_64, l2trap, l3p, l3_64, l3trap, expected result[1:0]}
  localparam int NVEC = 14;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b00_1_000_000_01,  // R3 level 0
    11'b00_0_111_111_01,  // R3 level 0, secure
    11'b01_0_111_111_01,  // R3 level 1 secure beats traps
    11'b01_1_111_111_10,  // R4 level-2 trap first
    11'b01_1_101_111_11,  // R4 level 2 not 64-bit
    11'b01_1_011_111_11,  // R4 level 2 not enabled
    11'b01_1_000_011_00,  // R4 level 3 absent
    11'b01_1_000_101_00,  // R4 level 3 not 64-bit
    11'b01_1_000_000_00,  // R4 complete
    11'b10_1_111_000_00,  // R5 level-2 flags ignored at level 2
    11'b10_1_111_111_11,  // R5 level-3 trap at level 2
    11'b10_0_000_111_01,  // R3 level 2 secure
    11'b11_1_111_111_00,  // R5 level 3 completes
    11'b11_0_000_000_01   // R3 level 3 secure
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [63:0] wd);
    @(negedge clk);
    req_write = wr;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_ctl(input logic [8:0] c);
    {cur_level, nonsecure, l2_enabled, l2_is_64bit, l2_trap,
     l3_present, l3_is_64bit, l3_trap} = c;
  endtask

  task automatic read_top(input logic [63:0] exp_main, input string req);
    set_ctl(9'b11_1_000_000);
    access(1'b0, '0);
    check(m_done && m_res == 2'b00 && m_rd == exp_main, req, m_rd, exp_main);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!m_done && m_rd == 64'd0, "R13 idle after reset", m_rd, 64'd0);

    // R7: enable flag out of reset
    set_ctl(9'b11_1_000_000);
    access(1'b0, '0);
    check(m_done && m_rd[0] == 1'b0, "R7 enable bit reset", {63'd0, m_rd[0]}, 64'd0);
    @(negedge clk);
    check(!m_done, "R2 done is one cycle", {63'd0, m_done}, 64'd0);

    // Permission table
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] er;
      logic [1:0] et;
      logic [5:0] ec;
      set_ctl(VEC[v][10:2]);
      er = VEC[v][1:0];
      et = er == 2'b10 ? 2'd2 : (er == 2'b11 ? 2'd3 : 2'd0);
      ec = er[1] ? 6'h18 : 6'h00;
      access(1'b0, '0);
      check(m_done && m_res == er, "R2 R3 R4 R5 result", {62'd0, m_res}, {62'd0, er});
      check(m_tgt == et && m_cls == ec, "R6 target/class",
            {56'd0, m_tgt, m_cls}, {56'd0, et, ec});
      check(a_done && a_res == er, "R12 absent permission", {62'd0, a_res}, {62'd0, er});
      @(negedge clk);
    end

    // R8 R9 R10 R12: full write in wide mode
    wide_pa_64k = 1'b1;
    set_ctl(9'b11_1_000_000);
    access(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check(m_done && m_res == 2'b00 && m_rd == 64'd0, "R13 write returns zero", m_rd, 64'd0);
    access(1'b0, '0);
    check(m_rd == 64'h000F_FFFF_FFFF_0001, "R8 R9 wide readback", m_rd, 64'h000F_FFFF_FFFF_0001);
    check(n_rd == 64'h0000_00FF_FFFF_0001, "R10 narrow width", n_rd, 64'h0000_00FF_FFFF_0001);
    check(a_rd == 64'd0, "R12 absent reads zero", a_rd, 64'd0);
    @(negedge clk);
    wide_pa_64k = 1'b0;
    read_top(64'h0000_FFFF_FFFF_0001, "R9 mode off hides top nibble");

    // R8 pattern write
    wide_pa_64k = 1'b1;
    access(1'b1, 64'h1234_5678_9ABC_DEF1);
    read_top(64'h0004_5678_9ABC_0001, "R8 pattern readback");

    // R11: trapped and undefined writes do not modify
    set_ctl(9'b01_1_111_000);
    access(1'b1, 64'h0);
    check(m_res == 2'b10, "R11 trapped write result", {62'd0, m_res}, 64'd2);
    read_top(64'h0004_5678_9ABC_0001, "R11 trapped write ignored");
    set_ctl(9'b00_1_000_000);
    access(1'b1, 64'h0);
    read_top(64'h0004_5678_9ABC_0001, "R11 undefined write ignored");

    // R1: other encoding neither answers nor writes
    req_crm = 4'b0101;
    access(1'b1, 64'h0);
    check(!m_done, "R1 foreign encoding no done", {63'd0, m_done}, 64'd0);
    req_crm = 4'b0100;
    req_op2 = 3'b001;
    access(1'b0, '0);
    check(!m_done, "R1 foreign op2 no done", {63'd0, m_done}, 64'd0);
    req_op2 = 3'b000;
    read_top(64'h0004_5678_9ABC_0001, "R1 foreign write ignored");

    // R7: clear enable bit by write
    access(1'b1, 64'h0000_0000_0001_0000);
    read_top(64'h0000_0000_0001_0000, "R7 enable cleared");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule